// File: doc/BRIEF.md
# Triggered Up-Counter with Slave Reset and Gating

This block is an up-counting timer whose count can be steered by an external trigger. A prescaler divides the internal clock. The counter advances by one on each prescaler tick. When the count reaches the active reload limit, the counter returns to zero and an update event loads the buffered reload and compare values into their active copies. Software programs the block through a write-only register port. That port carries the run enable, the slave mode, the trigger source, the edge and level polarity, an update-source restriction and the interrupt enable.

The trigger pin is brought into the clock domain by a two-flop synchronizer and then passed to an edge detector. In clear mode, a qualifying trigger edge resets the counter and the prescaler to zero. If updates are not restricted, the same edge also raises an update event. In gated mode, the counter advances only while the synchronized input sits at its active level. Each trigger event sets a sticky flag. The interrupt line follows that flag whenever the interrupt enable is set.

Top module: `slave_trig_timer`

## Requirements
- R1: While reset is held, and after it is released, the outputs are: count 0, active reload 0xFFFF, active compare 0, update pulse 0, flag 0 and interrupt 0. Register map by address: 0 control (bit0 run, bit1 restrict updates, bit2 interrupt enable), 1 slave setup, 2 prescaler divisor, 3 reload buffer, 4 compare buffer, 5 status, 6 event generation.
- R2: With run at 0 and no clear, the count holds. While running, the count rises by one every divisor+1 enabled cycles.
- R3: When a tick finds the count equal to the active reload value, the next count is 0. An update event pulse then copies the reload and compare buffers to the active outputs in that same cycle.
- R4: Slave setup bits [2:0] = 100 select clear mode. A qualifying edge on the selected input clears the counter and the prescaler at the third rising clock edge after the input change.
- R5: In clear mode with control bit1 = 0, the trigger clear also produces an update event. With bit1 = 1, it produces none, and the active values keep their old contents.
- R6: Slave setup bits [7:3] = 00101 select the channel input. Any other code selects no input, so no trigger events occur.
- R7: Slave setup bit8 = 0 with bit9 = 0 selects rising edges. Bit8 = 1 with bit9 = 0 selects falling edges. Both bits at 1 select both edges. Bit8 = 0 with bit9 = 1 acts as rising.
- R8: Slave setup bits [2:0] = 101 select gated mode. The counter and prescaler run only while the synchronized input equals the inverse of bit8, so bit8 = 1 means active low. The flag is set when the gate opens and when it closes.
- R9: A trigger event sets the flag. Writing 0 to status bit0 clears the flag. Writing 1 to it leaves the flag unchanged. A set in the same cycle wins over a clear.
- R10: The interrupt output is high exactly when the flag is set and control bit2 is 1.
- R11: Writing 1 to event-generation bit0 clears the counter and prescaler and produces one update event. If this coincides with a trigger clear, the result is a single clear and a single one-cycle update pulse.
- R12: Slave mode codes other than 100 and 101 make the counter free-running under the run bit, whatever the trigger input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| chan_in | input | 1 | Asynchronous trigger/gate channel input |
| count | output | 16 | Current counter value |
| reload_act | output | 16 | Active reload limit |
| cmp_act | output | 16 | Active compare value |
| upd_evt | output | 1 | One-cycle update event pulse |
| trig_flag | output | 1 | Sticky trigger flag |
| irq | output | 1 | Trigger interrupt request |

## Verification
Directed sequences cover several cases: the 0x35, 0x36, 0x00 wrap; a rising trigger in clear mode with updates allowed and with updates restricted; falling-edge polarity, where a rising edge must leave the flag alone; a non-matching source code, where toggling the pin must do nothing; and an active-low gate, where the count must freeze while the pin is high. The clear latency is tested by watching the flag stay low two edges after the pin change and go high on the third. A software update is placed on the same edge as a trigger clear, which shows whether the two collapse into one pulse. A long random phase then mixes register writes with pin toggles under short reload and prescaler values. A cycle-level reference model checks every output in every cycle, so wraps, prescaler phases and mode changes appear in many combinations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned ADDR_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SLAVE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd2;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
  localparam logic [ADDR_W-1:0] A_EVGEN  = 3'd6;

  // control bit positions
  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_URS  = 1;
  localparam int unsigned C_IE   = 2;
  localparam int unsigned CTRL_W = 3;

  typedef enum logic [2:0] {
    SM_FREE  = 3'b000,
    SM_CLEAR = 3'b100,
    SM_GATED = 3'b101
  } slave_mode_e;

  localparam logic [4:0] TSEL_CHAN = 5'b00101;

  typedef struct packed {
    logic       pol_c;
    logic       pol_n;
    logic [4:0] tsel;
    logic [2:0] mode;
  } slave_cfg_t;

  localparam int unsigned CFG_W = $bits(slave_cfg_t);

endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lev,
  output logic rise,
  output logic fall
);

  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // last synchroniser stage is the level; the extra stage holds history
  always_comb begin
    lev  = chain_q[STAGES-1];
    rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    fall = ~chain_q[STAGES-1] & chain_q[STAGES];
  end

  // R4
  no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
  import tmr_pkg::*;
(
  input  slave_cfg_t cfg,
  input  logic       run_en,
  input  logic       lev,
  input  logic       rise,
  input  logic       fall,
  output logic       trig_clr,
  output logic       flag_set,
  output logic       run
);

  logic edge_hit;
  logic gate_open;
  logic is_clear;
  logic is_gated;

  always_comb begin
    is_clear = (cfg.mode == SM_CLEAR);
    is_gated = (cfg.mode == SM_GATED);
    unique case ({cfg.pol_n, cfg.pol_c})
      2'b10:   edge_hit = fall;
      2'b11:   edge_hit = rise | fall;
      default: edge_hit = rise;
    endcase
    gate_open = lev ^ cfg.pol_n;
    trig_clr  = is_clear & edge_hit;
    flag_set  = trig_clr | (is_gated & (rise | fall));
    run       = run_en & (~is_gated | gate_open);
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic          upd_req,
  input  logic [PW-1:0] psc_div,
  input  logic [CW-1:0] reload_pre,
  input  logic [CW-1:0] cmp_pre,
  output logic [CW-1:0] count,
  output logic [CW-1:0] reload_act,
  output logic [CW-1:0] cmp_act,
  output logic          upd_evt
);

  logic [PW-1:0] psc_q, psc_d;
  logic [CW-1:0] cnt_d, rl_d, cp_d;
  logic          tick, wrap, upd_d;

  always_comb begin
    tick  = run & (psc_q >= psc_div);
    wrap  = tick & (count == reload_act) & ~clr;
    upd_d = upd_req | wrap;
    psc_d = psc_q;
    cnt_d = count;
    if (clr) begin
      psc_d = '0;
      cnt_d = '0;
    end else if (run) begin
      if (tick) begin
        psc_d = '0;
        cnt_d = wrap ? '0 : count + 1'b1;
      end else begin
        psc_d = psc_q + 1'b1;
      end
    end
    rl_d = upd_d ? reload_pre : reload_act;
    cp_d = upd_d ? cmp_pre : cmp_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q      <= '0;
      count      <= '0;
      reload_act <= '1;
      cmp_act    <= '0;
      upd_evt    <= 1'b0;
    end else begin
      psc_q      <= psc_d;
      count      <= cnt_d;
      reload_act <= rl_d;
      cmp_act    <= cp_d;
      upd_evt    <= upd_d;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count));

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= reload_act);

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && psc_q >= psc_div && count == reload_act) |=> (count == '0 && upd_evt));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R3
  preload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> (reload_act == $past(reload_pre) && cmp_act == $past(cmp_pre)));

endmodule

// File: rtl/slave_trig_timer.sv
module slave_trig_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned PW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              chan_in,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     reload_act,
  output logic [CW-1:0]     cmp_act,
  output logic              upd_evt,
  output logic              trig_flag,
  output logic              irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // register file
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  slave_cfg_t        cfg_q, cfg_d;
  logic [PW-1:0]     pdiv_q, pdiv_d;
  logic [CW-1:0]     rlp_q, rlp_d;
  logic [CW-1:0]     cpp_q, cpp_d;
  logic              flag_d;
  logic              sw_upd, stat_clr;

  logic src_sig, lev, rise, fall;
  logic trig_clr, flag_set, run;
  logic clr, upd_req;

  always_comb begin
    ctrl_d   = ctrl_q;
    cfg_d    = cfg_q;
    pdiv_d   = pdiv_q;
    rlp_d    = rlp_q;
    cpp_d    = cpp_q;
    sw_upd   = 1'b0;
    stat_clr = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        A_CTRL:   ctrl_d   = wr_data[CTRL_W-1:0];
        A_SLAVE:  cfg_d    = slave_cfg_t'(wr_data[CFG_W-1:0]);
        A_PSC:    pdiv_d   = wr_data[PW-1:0];
        A_RELOAD: rlp_d    = wr_data;
        A_CMP:    cpp_d    = wr_data;
        A_STAT:   stat_clr = ~wr_data[0];
        A_EVGEN:  sw_upd   = wr_data[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      pdiv_q <= '0;
      rlp_q  <= '1;
      cpp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cfg_q  <= cfg_d;
      pdiv_q <= pdiv_d;
      rlp_q  <= rlp_d;
      cpp_q  <= cpp_d;
    end
  end

  // trigger path
  always_comb src_sig = (cfg_q.tsel == TSEL_CHAN) & chan_in;

  tmr_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_ni),
    .din  (src_sig),
    .lev  (lev),
    .rise (rise),
    .fall (fall)
  );

  tmr_slave_ctl u_ctl (
    .cfg     (cfg_q),
    .run_en  (ctrl_q[C_RUN]),
    .lev     (lev),
    .rise    (rise),
    .fall    (fall),
    .trig_clr(trig_clr),
    .flag_set(flag_set),
    .run     (run)
  );

  always_comb begin
    clr     = trig_clr | sw_upd;
    upd_req = sw_upd | (trig_clr & ~ctrl_q[C_URS]);
  end

  tmr_count_core #(.CW(CW), .PW(PW)) u_core (
    .clk       (clk),
    .rst_n     (rst_ni),
    .run       (run),
    .clr       (clr),
    .upd_req   (upd_req),
    .psc_div   (pdiv_q),
    .reload_pre(rlp_q),
    .cmp_pre   (cpp_q),
    .count     (count),
    .reload_act(reload_act),
    .cmp_act   (cmp_act),
    .upd_evt   (upd_evt)
  );

  // sticky flag and interrupt
  always_comb begin
    flag_d = trig_flag;
    if (flag_set)      flag_d = 1'b1;
    else if (stat_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) trig_flag <= 1'b0;
    else         trig_flag <= flag_d;
  end

  assign irq = trig_flag & ctrl_q[C_IE];

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    flag_set |=> trig_flag);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_clr && !flag_set) |=> !trig_flag);

  // R5
  urs_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (trig_clr && ctrl_q[C_URS] && !sw_upd) |=> !upd_evt);

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (sw_upd && trig_clr) |=> (upd_evt && count == '0));

endmodule

// File: tb/slave_trig_timer_test.sv
module slave_trig_timer_test;
  localparam int CW = 16;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          chan_in = 1'b0;
  logic [CW-1:0] count, reload_act, cmp_act;
  logic          upd_evt, trig_flag, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  slave_trig_timer #(.CW(CW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .chan_in(chan_in), .count(count),
    .reload_act(reload_act), .cmp_act(cmp_act), .upd_evt(upd_evt),
    .trig_flag(trig_flag), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [1:0]    m_rs;
  logic [2:0]    m_s;
  logic [2:0]    m_ctrl;
  logic [9:0]    m_slv;
  logic [PW-1:0] m_pdiv, m_psc;
  logic [CW-1:0] m_rlp, m_cpp, m_cnt, m_rla, m_cpa;
  logic          m_flag, m_upd;

  function automatic logic edge_ok(logic [1:0] pol, logic r, logic f);
    // pol = {bit9, bit8}
    if (pol == 2'b01) return f;
    if (pol == 2'b11) return r | f;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= '0; m_s <= '0; m_ctrl <= '0; m_slv <= '0; m_pdiv <= '0; m_psc <= '0;
      m_rlp <= '1; m_cpp <= '0; m_cnt <= '0; m_rla <= '1; m_cpa <= '0;
      m_flag <= 1'b0; m_upd <= 1'b0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (m_rs[1]) begin : step
        logic sel, lev, r, f, tclr, gated, fset, run, sw, sclr, clr, tick, wrap, upd;
        sel   = (m_slv[7:3] == 5'b00101) & chan_in;
        lev   = m_s[1];
        r     = m_s[1] & ~m_s[2];
        f     = ~m_s[1] & m_s[2];
        gated = (m_slv[2:0] == 3'b101);
        tclr  = (m_slv[2:0] == 3'b100) & edge_ok(m_slv[9:8], r, f);
        fset  = tclr | (gated & (r | f));
        run   = m_ctrl[0] & (!gated | (lev ^ m_slv[8]));
        sw    = wr_en && wr_addr == 3'd6 && wr_data[0];
        sclr  = wr_en && wr_addr == 3'd5 && !wr_data[0];
        clr   = tclr | sw;
        tick  = run && (m_psc >= m_pdiv);
        wrap  = tick && (m_cnt == m_rla) && !clr;
        upd   = sw | (tclr & !m_ctrl[1]) | wrap;
        m_s   <= {m_s[1:0], sel};
        if (clr) begin m_cnt <= '0; m_psc <= '0; end
        else if (run) begin
          if (tick) begin m_psc <= '0; m_cnt <= wrap ? '0 : m_cnt + 1'b1; end
          else m_psc <= m_psc + 1'b1;
        end
        if (upd) begin m_rla <= m_rlp; m_cpa <= m_cpp; end
        m_upd  <= upd;
        m_flag <= fset ? 1'b1 : (sclr ? 1'b0 : m_flag);
        if (wr_en) begin
          case (wr_addr)
            3'd0: m_ctrl <= wr_data[2:0];
            3'd1: m_slv  <= wr_data[9:0];
            3'd2: m_pdiv <= wr_data[PW-1:0];
            3'd3: m_rlp  <= wr_data;
            3'd4: m_cpp  <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 count", count, m_cnt);
      chk("R3 reload_act", reload_act, m_rla);
      chk("R3 cmp_act", cmp_act, m_cpa);
      chk("R5 upd_evt", upd_evt, m_upd);
      chk("R9 trig_flag", trig_flag, m_flag);
      chk("R10 irq", irq, m_flag & m_ctrl[2]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [2:0] a, logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [CW-1:0] snap;
    int unsigned seed;
    seed = $urandom(32'd4242);

    // R1 reset state
    idle(2);
    chk("R1 count", count, 0); chk("R1 reload", reload_act, 16'hFFFF);
    chk("R1 cmp", cmp_act, 0); chk("R1 upd", upd_evt, 0);
    chk("R1 flag", trig_flag, 0); chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1;
    chk("R1 count after release", count, 0);

    // R2 hold while stopped
    idle(5);
    chk("R2 stopped", count, 0);

    // R3 wrap at 0x36 after software update loads reload (R11)
    wr(3'd3, 16'h0036);
    wr(3'd4, 16'h0011);
    chk("R3 not yet loaded", reload_act, 16'hFFFF);
    wr(3'd6, 16'h0001);
    chk("R11 sw update load", reload_act, 16'h0036);
    chk("R11 sw cmp load", cmp_act, 16'h0011);
    wr(3'd0, 16'h0001);
    for (int i = 0; i < 200 && count != 16'h0035; i++) @(negedge clk);
    chk("R3 reach 0x35", count, 16'h0035);
    @(negedge clk); chk("R3 at 0x36", count, 16'h0036);
    @(negedge clk); chk("R3 wrap to 0", count, 0); chk("R3 wrap update", upd_evt, 1);

    // R4/R5 clear mode, rising, updates allowed
    wr(3'd1, 16'h002C);
    wr(3'd3, 16'h0040);
    idle(7);
    chan_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 flag not yet", trig_flag, 0);
    @(negedge clk);
    chk("R4 cleared on third edge", count, 0);
    chk("R9 flag set", trig_flag, 1);
    chk("R5 update on trigger", upd_evt, 1);
    chk("R5 reload moved", reload_act, 16'h0040);

    // R9 status writes, R10 irq
    wr(3'd5, 16'h0001);
    chk("R9 write one keeps flag", trig_flag, 1);
    chk("R10 irq masked", irq, 0);
    wr(3'd0, 16'h0005);
    chk("R10 irq on", irq, 1);
    wr(3'd5, 16'h0000);
    chk("R9 write zero clears", trig_flag, 0);
    chk("R10 irq off", irq, 0);

    // R5 restricted updates
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'h0050);
    chan_in = 1'b0; idle(5);
    chan_in = 1'b1; idle(3);
    chk("R5 restricted cleared", count, 0);
    chk("R5 restricted no update", upd_evt, 0);
    chk("R5 reload kept", reload_act, 16'h0040);
    wr(3'd5, 16'h0000);

    // R7 falling polarity
    wr(3'd1, 16'h012C);
    chan_in = 1'b0; idle(5); wr(3'd5, 16'h0000);
    chan_in = 1'b1; idle(5);
    chk("R7 rising ignored", trig_flag, 0);
    chan_in = 1'b0; idle(3);
    chk("R7 falling clears", count, 0);
    chk("R7 falling flag", trig_flag, 1);
    wr(3'd5, 16'h0000);

    // R6 other source code
    wr(3'd1, 16'h0034);
    idle(4); wr(3'd5, 16'h0000);
    for (int k = 0; k < 4; k++) begin chan_in = ~chan_in; idle(4); end
    chk("R6 no trigger from unselected", trig_flag, 0);

    // R8 gated, active low
    wr(3'd3, 16'hFFFF); wr(3'd6, 16'h0001);
    chan_in = 1'b1;
    wr(3'd1, 16'h012D);
    idle(4); wr(3'd5, 16'h0000);
    snap = count; idle(6);
    chk("R8 gate closed holds", count, snap);
    chan_in = 1'b0; idle(3);
    chk("R8 gate open flag", trig_flag, 1);
    snap = count; @(negedge clk);
    chk("R8 gate open counts", count, snap + 1);
    wr(3'd5, 16'h0000);
    chan_in = 1'b1; idle(3);
    chk("R8 gate close flag", trig_flag, 1);

    // R11 software update on the same edge as trigger clear
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h002C);
    chan_in = 1'b0; idle(5);
    chan_in = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 coincide cleared", count, 0);
    chk("R11 coincide pulse", upd_evt, 1);
    @(negedge clk);
    chk("R11 single pulse", upd_evt, 0);
    chk("R11 single clear", count, 1);

    // R12 reserved mode is free-running; R2 prescaler
    wr(3'd1, 16'h002E);
    chan_in = 1'b0; idle(3);
    snap = count; chan_in = 1'b1; idle(4);
    chk("R12 free run", count, snap + 4);
    wr(3'd2, 16'h0002);
    idle(12);

    // random phase
    wr(3'd0, 16'h0005);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if ($urandom_range(0, 5) == 0) chan_in = ~chan_in;
      if ($urandom_range(0, 9) == 0) begin
        logic [2:0] a;
        logic [CW-1:0] d;
        a = 3'($urandom_range(0, 6));
        d = CW'($urandom);
        if (a == 3'd3) d = d & 16'h003F;
        if (a == 3'd2) d = d & 16'h0003;
        if (a == 3'd1 && $urandom_range(0, 1) == 1) d[7:3] = 5'b00101;
        if (a == 3'd0) d[0] = ($urandom_range(0, 3) != 0);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    idle(4);
    finish_run();
  end

endmodule